// File: doc/BRIEF.md
# Bit-Slip Word Aligner

This block sits directly after a deserializer on the receive side. It takes an 8-bit parallel word in every parallel clock and outputs a realigned 8-bit word. Each rising edge on the slip-request input moves the word boundary one bit later in the stream. Downstream logic that decides when to slip watches two outputs:

- the realigned data;
- a pattern-hit flag, raised when the two most recent output words match a programmable 16-bit alignment pattern.

The previous raw word and the current raw word together form a 16-bit window. A 3-bit offset picks 8 bits out of that window. The slip request crosses into the parallel clock domain through a two-flop synchronizer. A small state machine then turns each rising edge into exactly one single-cycle slip pulse. Its states are:

- **SLIP_ARMED**: waiting for the synchronized request to be high.
- **SLIP_FIRE**: the one cycle in which the slip pulse is issued.
- **SLIP_HOLD**: the request is still high after a slip.

Its transitions are:

- **arm_to_fire**: SLIP_ARMED to SLIP_FIRE, taken when the request is high.
- **fire_to_hold**: SLIP_FIRE to SLIP_HOLD, taken when the request is still high.
- **fire_to_arm**: SLIP_FIRE to SLIP_ARMED, taken when the request has already dropped.
- **hold_to_arm**: SLIP_HOLD to SLIP_ARMED, taken when the request drops.

Each slip pulse advances the offset by one, modulo 8.

Top module: `bsa_aligner`

## Requirements
- R1: While reset is high, and on the first clock after it, the offset is 0 and `rx_aligned` and `pat_hit` are 0. The stored previous output word is also 0, so the first word after reset is matched against a low pattern byte of zero.
- R2: With offset 0, `rx_aligned` equals the `rx_raw` word sampled at the previous rising edge.
- R3: With offset k, the output word is bits [k+7:k] of {previous raw word, current raw word}. Equivalently, the k least significant bits of the previous raw word become the k most significant bits of the output. For example, a repeating 0xF0 input gives 0x78 at k=1 and 0x0F at k=4.
- R4: Each rising edge of `slip_req` causes exactly one slip. Holding the request high for many cycles causes no further slips.
- R5: Count the rising clock edge that first samples `slip_req` high as edge 0. Output words registered at edges 0 to 3 use the old offset. The word registered at edge 4, and every word after it, uses the new offset.
- R6: The offset wraps modulo 8. Eight slips bring the output back to the raw word with one cycle of delay.
- R7: `pat_hit` is high in the cycle where both of these hold: `rx_aligned` equals `align_pat[15:8]`, and the previous output word equals `align_pat[7:0]`. Both comparisons use the pattern present at that edge. It is low in every other cycle, so it is a one-cycle pulse for each matching pair.
- R8: A request that is high for a single parallel clock cycle still produces exactly one slip, with the same timing as R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_raw | input | 8 | Raw word from the deserializer, first-received bit in the MSB |
| slip_req | input | 1 | Slip request; each rising edge moves the word boundary by one bit |
| align_pat | input | 16 | Alignment pattern: upper byte for the newer word, lower byte for the older word |
| rx_aligned | output | 8 | Realigned data word |
| pat_hit | output | 1 | One-cycle flag for a two-word pattern match |

## Verification
The hardest situation to reach from the ports is the exact cycle where the offset changes. The output word in that cycle already mixes bits of two raw words under the new offset. The pattern comparison at the same moment sees an older word that was produced under the old offset. The stimulus streams a repeating 0xF0 word, which makes every offset visible as a distinct value. It places the slip requests so that one slip lands exactly on the step from 0x1E to 0x0F. A pattern of 0x0F1E must then fire once at that boundary and never again. Requests held for one cycle and for ten cycles are both used. Varied data checks the bit splice across word edges.

// File: rtl/bsa_pkg.sv
`timescale 1ns/1ps
package bsa_pkg;

    // Slip request sequencer states
    typedef enum logic [1:0] {
        SLIP_ARMED = 2'd0,
        SLIP_FIRE  = 2'd1,
        SLIP_HOLD  = 2'd2
    } slip_state_e;

    // Width of the bit offset for a given word width
    function automatic int off_width(input int word_w);
        return (word_w > 1) ? $clog2(word_w) : 1;
    endfunction

endpackage

// File: rtl/bsa_req_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for the asynchronous slip request
module bsa_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_async,
    output logic req_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= 1'b0;
                    else     chain_q[s] <= req_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= 1'b0;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign req_sync = chain_q[STAGES-1];
endmodule

// File: rtl/bsa_slip_fsm.sv
`timescale 1ns/1ps
// Turns each rising edge of the synchronized request into one slip
// pulse and keeps the bit offset that the pulse advances.
module bsa_slip_fsm
    import bsa_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int OFF_W = off_width(DATA_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_s,
    output logic             slip,
    output logic [OFF_W-1:0] offset
);
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(DATA_W - 1);

    slip_state_e state_q, state_d;
    logic [OFF_W-1:0] off_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SLIP_ARMED;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLIP_ARMED: if (req_s)  state_d = SLIP_FIRE;   // arm_to_fire
            SLIP_FIRE:  state_d = req_s ? SLIP_HOLD        // fire_to_hold
                                        : SLIP_ARMED;      // fire_to_arm
            SLIP_HOLD:  if (!req_s) state_d = SLIP_ARMED;  // hold_to_arm
            default:    state_d = SLIP_ARMED;
        endcase
    end

    // Outputs
    always_comb begin
        slip = (state_q == SLIP_FIRE);
    end

    // Offset counter, modulo DATA_W
    always_ff @(posedge clk) begin
        if (rst)       off_q <= '0;
        else if (slip) off_q <= (off_q == OFF_LAST) ? '0 : off_q + 1'b1;
    end

    assign offset = off_q;
endmodule

// File: rtl/bsa_word_window.sv
`timescale 1ns/1ps
// Two-word window over the raw stream and offset-driven bit selection
module bsa_word_window
    import bsa_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int OFF_W = off_width(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] raw,
    input  logic [OFF_W-1:0]  offset,
    output logic [DATA_W-1:0] next_word,
    output logic [DATA_W-1:0] cur_word
);
    logic [DATA_W-1:0]   prev_raw_q;
    logic [DATA_W-1:0]   data_q;
    logic [2*DATA_W-1:0] window;
    logic [DATA_W-1:0]   cand [DATA_W];

    assign window = {prev_raw_q, raw};

    // One candidate word per possible offset
    generate
        for (genvar k = 0; k < DATA_W; k++) begin : g_cand
            assign cand[k] = window[k +: DATA_W];
        end
    endgenerate

    assign next_word = cand[offset];

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_raw_q <= '0;
            data_q     <= '0;
        end else begin
            prev_raw_q <= raw;
            data_q     <= next_word;
        end
    end

    assign cur_word = data_q;
endmodule

// File: rtl/bsa_pattern_match.sv
`timescale 1ns/1ps
// Two-word pattern compare: newer word against the upper half,
// older word against the lower half.
module bsa_pattern_match #(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DATA_W-1:0]   next_word,
    input  logic [DATA_W-1:0]   cur_word,
    input  logic [2*DATA_W-1:0] pattern,
    output logic                hit
);
    logic hi_eq, lo_eq, hit_q;

    assign hi_eq = (next_word == pattern[2*DATA_W-1:DATA_W]);
    assign lo_eq = (cur_word  == pattern[DATA_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) hit_q <= 1'b0;
        else     hit_q <= hi_eq && lo_eq;
    end

    assign hit = hit_q;
endmodule

// File: rtl/bsa_aligner.sv
`timescale 1ns/1ps
module bsa_aligner
    import bsa_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DATA_W-1:0]   rx_raw,
    input  logic                slip_req,
    input  logic [2*DATA_W-1:0] align_pat,
    output logic [DATA_W-1:0]   rx_aligned,
    output logic                pat_hit
);
    localparam int OFF_W = off_width(DATA_W);

    logic              req_s;
    logic              slip_pulse;
    logic [OFF_W-1:0]  slip_off;
    logic [DATA_W-1:0] word_next;
    logic [DATA_W-1:0] word_cur;

    bsa_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .req_async (slip_req),
        .req_sync  (req_s)
    );

    bsa_slip_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .req_s  (req_s),
        .slip   (slip_pulse),
        .offset (slip_off)
    );

    bsa_word_window #(.DATA_W(DATA_W)) u_win (
        .clk       (clk),
        .rst       (rst),
        .raw       (rx_raw),
        .offset    (slip_off),
        .next_word (word_next),
        .cur_word  (word_cur)
    );

    bsa_pattern_match #(.DATA_W(DATA_W)) u_match (
        .clk       (clk),
        .rst       (rst),
        .next_word (word_next),
        .cur_word  (word_cur),
        .pattern   (align_pat),
        .hit       (pat_hit)
    );

    assign rx_aligned = word_cur;
endmodule

// File: rtl/bsa_aligner_chk.sv
`timescale 1ns/1ps
module bsa_aligner_chk #(
    parameter int DATA_W = 8,
    parameter int OFF_W  = 3
) (
    input logic                clk,
    input logic                rst,
    input logic [DATA_W-1:0]   rx_aligned,
    input logic                pat_hit,
    input logic [2*DATA_W-1:0] align_pat,
    input logic [OFF_W-1:0]    slip_off,
    input logic                slip_pulse
);
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(DATA_W - 1);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (rx_aligned == '0 && !pat_hit && slip_off == '0));

    assert_one_pulse_per_edge_R4: assert property (@(posedge clk) disable iff (rst)
        slip_pulse |=> !slip_pulse);

    // R5: the offset moves only in the cycle after a slip pulse
    assert_offset_after_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && slip_off != $past(slip_off)) |-> $past(slip_pulse));

    assert_offset_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && slip_off != $past(slip_off)) |->
        (slip_off == (($past(slip_off) == OFF_LAST) ? '0 : $past(slip_off) + 1'b1)));

    assert_hit_needs_match_R7: assert property (@(posedge clk) disable iff (rst)
        pat_hit |-> (rx_aligned == $past(align_pat[2*DATA_W-1:DATA_W]) &&
                     $past(rx_aligned) == $past(align_pat[DATA_W-1:0])));

    assert_match_gives_hit_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) &&
         rx_aligned == $past(align_pat[2*DATA_W-1:DATA_W]) &&
         $past(rx_aligned) == $past(align_pat[DATA_W-1:0])) |-> pat_hit);
endmodule

bind bsa_aligner bsa_aligner_chk #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_aligned (rx_aligned),
    .pat_hit    (pat_hit),
    .align_pat  (align_pat),
    .slip_off   (slip_off),
    .slip_pulse (slip_pulse)
);

// File: tb/bsa_aligner_test.sv
`timescale 1ns/1ps
module bsa_aligner_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] rx_raw = 8'hA5;
    logic         slip_req = 1'b0;
    logic [2*W-1:0] align_pat = 16'h3C00;
    logic [W-1:0] rx_aligned;
    logic         pat_hit;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bsa_aligner uut (
        .clk        (clk),
        .rst        (rst),
        .rx_raw     (rx_raw),
        .slip_req   (slip_req),
        .align_pat  (align_pat),
        .rx_aligned (rx_aligned),
        .pat_hit    (pat_hit)
    );

    typedef struct {
        logic [W-1:0] data;
        logic         hit;
        string        tag;
    } exp_t;

    exp_t sb[$];

    // Reference model state
    logic [W-1:0] m_prev_raw = '0;
    logic [W-1:0] m_prev_out = '0;
    int           m_off      = 0;
    int           m_cd       = 0;
    logic         m_last_req = 1'b0;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: applies one word (and request level) per cycle, pushes the expectation
    task automatic drive_word(input logic [W-1:0] w, input logic req, input string tag);
        logic [2*W-1:0] win;
        exp_t it;
        rx_raw   = w;
        slip_req = req;
        if (req && !m_last_req) m_cd = 5;   // R5: offset switches four words later
        m_last_req = req;
        if (m_cd != 0) begin
            m_cd--;
            if (m_cd == 0) m_off = (m_off + 1) % W;
        end
        win     = {m_prev_raw, w} >> m_off;
        it.data = win[W-1:0];
        it.hit  = (it.data == align_pat[2*W-1:W]) && (m_prev_out == align_pat[W-1:0]);
        it.tag  = tag;
        sb.push_back(it);
        m_prev_raw = w;
        m_prev_out = it.data;
        @(negedge clk);
    endtask

    task automatic do_slip(input int hold, input logic [W-1:0] base, input int mult,
                           input string tag);
        for (int i = 0; i < hold + 8; i++)
            drive_word(base ^ W'(i * mult), (i < hold), tag);
    endtask

    // Monitor: compares each produced word against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() != 0) begin
                exp_t e;
                e = sb.pop_front();
                check({e.tag, " data"}, 16'(rx_aligned), 16'(e.data));
                check({e.tag, " hit (R7)"}, 16'(pat_hit), 16'(e.hit));
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset data", 16'(rx_aligned), 16'h0000);
        check("R1 reset hit", 16'(pat_hit), 16'h0000);
        rst = 1'b0;

        // R1/R2: offset 0 pass-through; first word meets the cleared previous word
        drive_word(8'h3C, 1'b0, "R1 first word");
        drive_word(8'h5A, 1'b0, "R2");
        drive_word(8'hC3, 1'b0, "R2");
        drive_word(8'h81, 1'b0, "R2");
        drive_word(8'hFF, 1'b0, "R2");
        drive_word(8'h00, 1'b0, "R2");

        // Repeating F0 with pattern 0F1E
        align_pat = 16'h0F1E;
        repeat (3) drive_word(8'hF0, 1'b0, "R2 stream");
        do_slip(1, 8'hF0, 0, "R8 single-cycle request");
        do_slip(1, 8'hF0, 0, "R5 slip timing");
        do_slip(2, 8'hF0, 0, "R5 slip timing");
        do_slip(10, 8'hF0, 0, "R4 held request");

        // R3: varied data spliced at offset 4
        for (int i = 0; i < 12; i++) drive_word(W'(i * 37 + 11), 1'b0, "R3 offset 4");

        // R6: four more slips wrap to offset 0
        for (int s = 0; s < 4; s++) do_slip(1, 8'h6B, 29, "R6 wrap");
        for (int i = 0; i < 6; i++) drive_word(W'(i * 53 + 7), 1'b0, "R6 offset 0");

        // R3: offset 1 with varied data
        do_slip(3, 8'h96, 41, "R3 offset 1");
        for (int i = 0; i < 6; i++) drive_word(W'(i * 71 + 3), 1'b0, "R3 offset 1");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule